// File: doc/BRIEF.md
# Coprocessor Integer Execute Unit

This block carries out the integer data-processing part of a coprocessor. It holds sixteen 64-bit registers and accepts one 32-bit instruction word per clock. Each instruction names a destination and up to two source registers. The block reads the sources and the destination's old contents in the same cycle, computes the result, and writes it back at the next clock edge. The operations are add, subtract, negate and absolute value in 32-bit and 64-bit forms, a multiply family, and shifts by an immediate.

Any instruction that needs a register's earlier value simply issues after the producing instruction; there is no stall. A 32-bit operation works on the low half of a register and keeps the high half. A separate fill port loads a whole register from outside, so that the surrounding logic can supply operands. Each executed instruction is reported on a write-back port that shows the destination index and the full 64-bit value now held there. An encoding the block does not support raises a one-cycle illegal flag and writes nothing.

Top module: `cxu_int_exec`

## Requirements
- R1: The destination index is taken from instruction bits 15:12, the first source from bits 19:16 and the second source from bits 3:0. One cycle after an accepted instruction, `wb_valid_o` is 1 and `wb_idx_o` equals the destination index.
- R2: Group 3 (bits 21:20 = 3), operation field (bits 7:5) values 4 to 7, selects add32, add64, sub32 and sub64 in that order. Each result is computed from src1 and src2 and wraps modulo 2^32 or 2^64.
- R3: Group 3, operation field values 0 to 3, selects abs32, abs64, neg32 and neg64 of src1 in that order. The absolute value of the most negative number is that same number.
- R4: Group 1 (bits 21:20 = 1), operation field values 0 to 3, selects the following, each keeping the low 32 or 64 bits:
  - 0: a 32-bit product src1*src2.
  - 1: a 64-bit product src1*src2.
  - 2: dest + src1*src2 on 32 bits.
  - 3: dest - src1*src2 on 32 bits.
- R5: Every 32-bit operation leaves bits 63:32 of the destination equal to their value before the instruction. This covers abs32, neg32, add32, sub32, mul32, the two accumulates and the 32-bit shift.
- R6: Group 0 is a 32-bit shift of src1 and group 2 is a 64-bit shift of src1. The amount is a 7-bit two's-complement number whose bits 3:0 are instruction bits 3:0 and whose bits 6:4 are instruction bits 7:5. A positive amount shifts left and a negative amount shifts right by its magnitude. Bits shifted past the width are lost.
- R7: A right shift is arithmetic. A right shift by the word width or more (up to 64) gives all copies of the sign bit.
- R8: Group 1 with operation field 4 to 7 is illegal. One cycle later `illegal_o` is 1 and `wb_valid_o` is 0, and no register changes.
- R9: After reset, all registers read as zero and `wb_valid_o` and `illegal_o` are 0.
- R10: `fill_we_i` writes `fill_data_i` into register `fill_idx_i` at the clock edge. An instruction issued in the same cycle reads the values from before the fill. If both target the same register, the instruction's result is kept.
- R11: When no instruction is issued, `wb_valid_o` and `illegal_o` are 0 in the next cycle. An instruction issued in the cycle right after another sees that instruction's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| fill_we_i | input | 1 | Register fill strobe |
| fill_idx_i | input | 4 | Register to fill |
| fill_data_i | input | 64 | Fill value |
| wb_valid_o | output | 1 | A register was written by an instruction |
| wb_idx_o | output | 4 | Index of the written register |
| wb_data_o | output | 64 | New contents of that register |
| illegal_o | output | 1 | Previous instruction was unsupported |

## Verification
Two writes can land in the same cycle: the fill port and an instruction's write-back, possibly to the same register. The instruction may also read the very register being filled. The random phase asserts fills on about a third of the cycles, with indices drawn from the same small set as the instruction operands. A directed case fills the destination and a source of an add in the same cycle. The bench model applies the instruction's operand read before the fill and the instruction's write after it. Every later write-back and read-back must then agree with that ordering.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

  localparam int unsigned INSTR_W     = 32;
  localparam int unsigned REG_FIELD_W = 4;
  localparam int unsigned NUM_REGS    = 1 << REG_FIELD_W;
  localparam int unsigned SHAMT_W     = 7;
  localparam int unsigned GRP_W       = 2;
  localparam int unsigned OPSEL_W     = 3;

  // field positions the decoder depends on
  localparam int unsigned DST_LSB  = 12;
  localparam int unsigned SRC1_LSB = 16;
  localparam int unsigned SRC2_LSB = 0;
  localparam int unsigned GRP_LSB  = 20;
  localparam int unsigned OPS_LSB  = 5;

  typedef enum logic [3:0] {
    XOP_NONE,
    XOP_SH32,
    XOP_SH64,
    XOP_MUL32,
    XOP_MUL64,
    XOP_MAC32,
    XOP_MSC32,
    XOP_ABS32,
    XOP_ABS64,
    XOP_NEG32,
    XOP_NEG64,
    XOP_ADD32,
    XOP_ADD64,
    XOP_SUB32,
    XOP_SUB64
  } xop_e;

  typedef struct packed {
    logic                   legal;
    xop_e                   op;
    logic [REG_FIELD_W-1:0] dst;
    logic [REG_FIELD_W-1:0] src1;
    logic [REG_FIELD_W-1:0] src2;
    logic [SHAMT_W-1:0]     shamt;
  } xctrl_t;

endpackage

// File: rtl/cxu_rst_sync.sv
module cxu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/cxu_decode.sv
module cxu_decode
  import cxu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output xctrl_t             ctrl_o
);

  logic [GRP_W-1:0]   grp;
  logic [OPSEL_W-1:0] opsel;
  logic               unused_bits;

  assign grp         = instr_i[GRP_LSB +: GRP_W];
  assign opsel       = instr_i[OPS_LSB +: OPSEL_W];
  assign unused_bits = ^{instr_i[INSTR_W-1:GRP_LSB+GRP_W],
                         instr_i[DST_LSB-1:OPS_LSB+OPSEL_W],
                         instr_i[OPS_LSB-1:SRC2_LSB+REG_FIELD_W]};

  always_comb begin
    ctrl_o       = '0;
    ctrl_o.op    = XOP_NONE;
    ctrl_o.legal = 1'b1;
    ctrl_o.dst   = instr_i[DST_LSB  +: REG_FIELD_W];
    ctrl_o.src1  = instr_i[SRC1_LSB +: REG_FIELD_W];
    ctrl_o.src2  = instr_i[SRC2_LSB +: REG_FIELD_W];
    // signed amount: high part from the operation field, low part from src2
    ctrl_o.shamt = {opsel, instr_i[SRC2_LSB +: REG_FIELD_W]};

    unique case (grp)
      2'd0: ctrl_o.op = XOP_SH32;
      2'd2: ctrl_o.op = XOP_SH64;
      2'd1: begin
        unique case (opsel)
          3'd0:    ctrl_o.op = XOP_MUL32;
          3'd1:    ctrl_o.op = XOP_MUL64;
          3'd2:    ctrl_o.op = XOP_MAC32;
          3'd3:    ctrl_o.op = XOP_MSC32;
          default: ctrl_o.legal = 1'b0;
        endcase
      end
      default: begin
        unique case (opsel)
          3'd0:    ctrl_o.op = XOP_ABS32;
          3'd1:    ctrl_o.op = XOP_ABS64;
          3'd2:    ctrl_o.op = XOP_NEG32;
          3'd3:    ctrl_o.op = XOP_NEG64;
          3'd4:    ctrl_o.op = XOP_ADD32;
          3'd5:    ctrl_o.op = XOP_ADD64;
          3'd6:    ctrl_o.op = XOP_SUB32;
          default: ctrl_o.op = XOP_SUB64;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/cxu_regfile.sv
module cxu_regfile #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_we_i,
  input  logic [IDX_W-1:0]  exec_idx_i,
  input  logic [DATA_W-1:0] exec_data_i,
  input  logic              fill_we_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  input  logic [IDX_W-1:0]  rd_c_idx_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [DATA_W-1:0] rd_c_o
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              hit_exec;
    logic              hit_fill;
    logic              en;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      hit_exec = exec_we_i && (exec_idx_i == IDX_W'(g));
      hit_fill = fill_we_i && (fill_idx_i == IDX_W'(g));
      en       = hit_exec || hit_fill;
      // an instruction result wins over a fill to the same register
      nxt      = hit_exec ? exec_data_i : fill_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (en) begin
        regs_q[g] <= nxt;
      end
    end
  end

  assign rd_a_o = regs_q[rd_a_idx_i];
  assign rd_b_o = regs_q[rd_b_idx_i];
  assign rd_c_o = regs_q[rd_c_idx_i];

endmodule

// File: rtl/cxu_alu.sv
module cxu_alu
  import cxu_pkg::*;
#(
  parameter int unsigned HALF_W   = 32,
  localparam int unsigned DATA_W  = 2 * HALF_W
) (
  input  xctrl_t            ctrl_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o
);

  logic [HALF_W-1:0]  lo1;
  logic [HALF_W-1:0]  lo2;
  logic [HALF_W-1:0]  lod;
  logic [SHAMT_W-1:0] sh_raw;
  logic [SHAMT_W-1:0] sh_mag;
  logic               sh_right;
  logic [HALF_W-1:0]  sh32_l;
  logic [HALF_W-1:0]  sh32_r;
  logic [DATA_W-1:0]  sh64_l;
  logic [DATA_W-1:0]  sh64_r;
  logic [HALF_W-1:0]  prod32;
  logic [DATA_W-1:0]  prod64;

  assign lo1      = src1_i[HALF_W-1:0];
  assign lo2      = src2_i[HALF_W-1:0];
  assign lod      = dst_i[HALF_W-1:0];
  assign sh_raw   = ctrl_i.shamt;
  assign sh_right = sh_raw[SHAMT_W-1];
  assign sh_mag   = sh_right ? (-sh_raw) : sh_raw;

  assign sh32_l = lo1 << sh_mag;
  assign sh32_r = $signed(lo1) >>> sh_mag;
  assign sh64_l = src1_i << sh_mag;
  assign sh64_r = $signed(src1_i) >>> sh_mag;

  assign prod32 = lo1 * lo2;
  assign prod64 = src1_i * src2_i;

  always_comb begin
    res_o = dst_i;
    unique case (ctrl_i.op)
      XOP_SH32:  res_o[HALF_W-1:0] = sh_right ? sh32_r : sh32_l;
      XOP_SH64:  res_o             = sh_right ? sh64_r : sh64_l;
      XOP_MUL32: res_o[HALF_W-1:0] = prod32;
      XOP_MUL64: res_o             = prod64;
      XOP_MAC32: res_o[HALF_W-1:0] = lod + prod32;
      XOP_MSC32: res_o[HALF_W-1:0] = lod - prod32;
      XOP_ABS32: res_o[HALF_W-1:0] = lo1[HALF_W-1] ? (-lo1) : lo1;
      XOP_ABS64: res_o             = src1_i[DATA_W-1] ? (-src1_i) : src1_i;
      XOP_NEG32: res_o[HALF_W-1:0] = -lo1;
      XOP_NEG64: res_o             = -src1_i;
      XOP_ADD32: res_o[HALF_W-1:0] = lo1 + lo2;
      XOP_ADD64: res_o             = src1_i + src2_i;
      XOP_SUB32: res_o[HALF_W-1:0] = lo1 - lo2;
      XOP_SUB64: res_o             = src1_i - src2_i;
      default:   res_o             = dst_i;
    endcase
  end

endmodule

// File: rtl/cxu_int_exec.sv
module cxu_int_exec
  import cxu_pkg::*;
#(
  parameter int unsigned HALF_W  = 32,
  localparam int unsigned DATA_W = 2 * HALF_W,
  localparam int unsigned IDX_W  = REG_FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [31:0]       instr_i,
  input  logic              fill_we_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              illegal_o
);

  logic              rst_sync_n;
  xctrl_t            ctrl;
  logic [DATA_W-1:0] src1_rdata;
  logic [DATA_W-1:0] src2_rdata;
  logic [DATA_W-1:0] dst_rdata;
  logic [DATA_W-1:0] alu_res;
  logic              exec_we;

  logic              wb_valid_d, wb_valid_q;
  logic [IDX_W-1:0]  wb_idx_d,   wb_idx_q;
  logic [DATA_W-1:0] wb_data_d,  wb_data_q;
  logic              illegal_d,  illegal_q;

  cxu_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cxu_decode u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  assign exec_we = issue_i && ctrl.legal;

  cxu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .exec_we_i   (exec_we),
    .exec_idx_i  (ctrl.dst),
    .exec_data_i (alu_res),
    .fill_we_i   (fill_we_i),
    .fill_idx_i  (fill_idx_i),
    .fill_data_i (fill_data_i),
    .rd_a_idx_i  (ctrl.src1),
    .rd_b_idx_i  (ctrl.src2),
    .rd_c_idx_i  (ctrl.dst),
    .rd_a_o      (src1_rdata),
    .rd_b_o      (src2_rdata),
    .rd_c_o      (dst_rdata)
  );

  cxu_alu #(.HALF_W(HALF_W)) u_alu (
    .ctrl_i (ctrl),
    .src1_i (src1_rdata),
    .src2_i (src2_rdata),
    .dst_i  (dst_rdata),
    .res_o  (alu_res)
  );

  always_comb begin
    wb_valid_d = exec_we;
    illegal_d  = issue_i && !ctrl.legal;
    wb_idx_d   = ctrl.dst;
    wb_data_d  = alu_res;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_valid_q <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      wb_valid_q <= wb_valid_d;
      illegal_q  <= illegal_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else if (exec_we) begin
      wb_idx_q  <= wb_idx_d;
      wb_data_q <= wb_data_d;
    end
  end

  assign wb_valid_o = wb_valid_q;
  assign wb_idx_o   = wb_idx_q;
  assign wb_data_o  = wb_data_q;
  assign illegal_o  = illegal_q;

endmodule

// File: rtl/cxu_int_exec_chk.sv
module cxu_int_exec_chk #(
  parameter int unsigned HALF_W  = 32,
  localparam int unsigned DATA_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic [31:0]       instr_i,
  input logic              wb_valid_o,
  input logic [3:0]        wb_idx_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] dst_rd
);

  logic bad_enc;
  logic narrow_op;

  assign bad_enc   = (instr_i[21:20] == 2'd1) && instr_i[7];
  assign narrow_op = (instr_i[21:20] == 2'd0)
                  || ((instr_i[21:20] == 2'd1) && !instr_i[7] && (instr_i[7:5] != 3'd1))
                  || ((instr_i[21:20] == 2'd3) && !instr_i[5]);

  // R8
  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_valid_o);

  // R8
  p_bad_enc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && bad_enc) |=> (illegal_o && !wb_valid_o));

  // R1
  p_dest_idx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !bad_enc) |=> (wb_valid_o && wb_idx_o == $past(instr_i[15:12])));

  // R5
  p_hi_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && narrow_op) |=> (wb_data_o[DATA_W-1:HALF_W] == $past(dst_rd[DATA_W-1:HALF_W])));

  // R11
  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> (!wb_valid_o && !illegal_o));

endmodule

bind cxu_int_exec cxu_int_exec_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .issue_i    (issue_i),
  .instr_i    (instr_i),
  .wb_valid_o (wb_valid_o),
  .wb_idx_o   (wb_idx_o),
  .wb_data_o  (wb_data_o),
  .illegal_o  (illegal_o),
  .dst_rd     (dst_rdata)
);

// File: tb/cxu_int_exec_tb_top.sv
module cxu_int_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] instr;
  logic        fwe;
  logic [3:0]  fidx;
  logic [63:0] fdata;
  logic        wb_valid;
  logic [3:0]  wb_idx;
  logic [63:0] wb_data;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [63:0] model [16];

  always #2 clk = ~clk;

  cxu_int_exec dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .issue_i     (issue),
    .instr_i     (instr),
    .fill_we_i   (fwe),
    .fill_idx_i  (fidx),
    .fill_data_i (fdata),
    .wb_valid_o  (wb_valid),
    .wb_idx_o    (wb_idx),
    .wb_data_o   (wb_data),
    .illegal_o   (illegal)
  );

  function automatic logic [31:0] mk(input logic [1:0] grp, input logic [2:0] op,
                                     input logic [3:0] d, input logic [3:0] s1,
                                     input logic [3:0] s2);
    return {10'b0, grp, s1, d, 4'b0, op, 1'b0, s2};
  endfunction

  function automatic logic [31:0] mk_sh(input bit wide, input logic [3:0] d,
                                        input logic [3:0] s1, input int amt);
    logic [6:0] a7;
    a7 = 7'(amt);
    return mk(wide ? 2'd2 : 2'd0, a7[6:4], d, s1, a7[3:0]);
  endfunction

  function automatic logic [31:0] shift_w(input logic [31:0] a, input int sh);
    int m;
    if (sh >= 0) return (sh >= 32) ? 32'd0 : (a << sh);
    m = -sh;
    if (m >= 32) return {32{a[31]}};
    return 32'($signed(a) >>> m);
  endfunction

  function automatic logic [63:0] shift_d(input logic [63:0] a, input int sh);
    int m;
    if (sh >= 0) return a << sh;
    m = -sh;
    if (m >= 64) return {64{a[63]}};
    return 64'($signed(a) >>> m);
  endfunction

  // returns {legal, new destination value}
  function automatic logic [64:0] predict(input logic [31:0] ins, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] d);
    logic [63:0] v;
    logic [31:0] p;
    logic signed [6:0] s7;
    int sh;
    v  = d;
    s7 = {ins[7:5], ins[3:0]};
    sh = s7;
    p  = a[31:0] * b[31:0];
    case ({ins[21:20], ins[7:5]})
      5'b01_000: v[31:0] = p;
      5'b01_001: v = a * b;
      5'b01_010: v[31:0] = d[31:0] + p;
      5'b01_011: v[31:0] = d[31:0] - p;
      5'b11_000: v[31:0] = a[31] ? (32'd0 - a[31:0]) : a[31:0];
      5'b11_001: v = a[63] ? (64'd0 - a) : a;
      5'b11_010: v[31:0] = 32'd0 - a[31:0];
      5'b11_011: v = 64'd0 - a;
      5'b11_100: v[31:0] = a[31:0] + b[31:0];
      5'b11_101: v = a + b;
      5'b11_110: v[31:0] = a[31:0] - b[31:0];
      5'b11_111: v = a - b;
      default: begin
        if (ins[21:20] == 2'd0)      v[31:0] = shift_w(a[31:0], sh);
        else if (ins[21:20] == 2'd2) v = shift_d(a, sh);
        else return {1'b0, d};
      end
    endcase
    return {1'b1, v};
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    if (ins[21:20] == 2'd0 || ins[21:20] == 2'd2) return "R6/R7";
    if (ins[21:20] == 2'd1) return ins[7] ? "R8" : "R4";
    return ins[7] ? "R2" : "R3";
  endfunction

  function automatic bit is_narrow(input logic [31:0] ins);
    if (ins[21:20] == 2'd0) return 1'b1;
    if (ins[21:20] == 2'd1) return !ins[7] && ins[7:5] != 3'd1;
    if (ins[21:20] == 2'd3) return !ins[5];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare one edge later
  task automatic step(input bit iss, input logic [31:0] ins, input bit fw,
                      input logic [3:0] fi, input logic [63:0] fd, input string note);
    logic [64:0] pr;
    logic [63:0] old_hi_src;
    string t;
    @(negedge clk);
    issue = iss; instr = ins; fwe = fw; fidx = fi; fdata = fd;
    pr = predict(ins, model[ins[19:16]], model[ins[3:0]], model[ins[15:12]]);
    old_hi_src = model[ins[15:12]];
    t = {tag_of(ins), note};
    @(posedge clk);
    #1;
    if (fw) model[fi] = fd;
    if (iss && pr[64]) model[ins[15:12]] = pr[63:0];
    if (!iss) begin
      check(!wb_valid && !illegal, "R11 idle", {62'd0, wb_valid, illegal}, 64'd0);
    end else if (!pr[64]) begin
      check(illegal && !wb_valid, {t, " illegal"}, {62'd0, wb_valid, illegal}, 64'd1);
    end else begin
      check(wb_valid && !illegal && wb_idx == ins[15:12], "R1 index",
            {59'd0, wb_valid, wb_idx}, {59'd0, 1'b1, ins[15:12]});
      check(wb_data == pr[63:0], t, wb_data, pr[63:0]);
      if (is_narrow(ins))
        check(wb_data[63:32] == old_hi_src[63:32], "R5 high half",
              {32'd0, wb_data[63:32]}, {32'd0, old_hi_src[63:32]});
    end
  endtask

  task automatic fill(input logic [3:0] i, input logic [63:0] v);
    step(1'b0, 32'd0, 1'b1, i, v, "");
  endtask

  // read a register back through add64 with a register known to hold zero
  task automatic peek(input logic [3:0] r, input logic [3:0] zr, input logic [3:0] scratch,
                      input string note);
    step(1'b1, mk(2'd3, 3'd5, scratch, r, zr), 1'b0, 4'd0, 64'd0, note);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    for (int i = 0; i < 16; i++) model[i] = 64'd0;
    issue = 1'b0; instr = '0; fwe = 1'b0; fidx = '0; fdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!wb_valid && !illegal, "R9 reset outputs", {62'd0, wb_valid, illegal}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9: registers clear after reset
    peek(4'd7, 4'd0, 4'd9, " R9 reset value");

    // R3 corners
    fill(4'd1, 64'h1234_5678_8000_0000);
    step(1'b1, mk(2'd3, 3'd0, 4'd2, 4'd1, 4'd0), 1'b0, 4'd0, 64'd0, " abs32 min");
    fill(4'd3, 64'h8000_0000_0000_0000);
    step(1'b1, mk(2'd3, 3'd1, 4'd4, 4'd3, 4'd0), 1'b0, 4'd0, 64'd0, " abs64 min");
    step(1'b1, mk(2'd3, 3'd3, 4'd5, 4'd1, 4'd0), 1'b0, 4'd0, 64'd0, " neg64");

    // R2 wrap
    fill(4'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b1, mk(2'd3, 3'd5, 4'd8, 4'd6, 4'd6), 1'b0, 4'd0, 64'd0, " add64 wrap");
    step(1'b1, mk(2'd3, 3'd6, 4'd8, 4'd0, 4'd6), 1'b0, 4'd0, 64'd0, " sub32 wrap");

    // R6 and R7 shift corners
    step(1'b1, mk_sh(1'b1, 4'd10, 4'd3, -64), 1'b0, 4'd0, 64'd0, " R7 sh64 right 64");
    step(1'b1, mk_sh(1'b1, 4'd10, 4'd6, 63), 1'b0, 4'd0, 64'd0, " sh64 left 63");
    step(1'b1, mk_sh(1'b0, 4'd11, 4'd1, -1), 1'b0, 4'd0, 64'd0, " R7 sh32 right 1");
    step(1'b1, mk_sh(1'b0, 4'd11, 4'd1, -40), 1'b0, 4'd0, 64'd0, " R7 sh32 right 40");
    step(1'b1, mk_sh(1'b0, 4'd11, 4'd6, 40), 1'b0, 4'd0, 64'd0, " sh32 left 40");

    // R4 multiplies
    fill(4'd12, 64'h0000_0001_0001_0003);
    step(1'b1, mk(2'd1, 3'd1, 4'd13, 4'd12, 4'd6), 1'b0, 4'd0, 64'd0, " mul64");
    step(1'b1, mk(2'd1, 3'd2, 4'd13, 4'd12, 4'd12), 1'b0, 4'd0, 64'd0, " mac32");
    step(1'b1, mk(2'd1, 3'd3, 4'd13, 4'd12, 4'd6), 1'b0, 4'd0, 64'd0, " msc32");

    // R8: illegal leaves destination untouched
    step(1'b1, mk(2'd1, 3'd5, 4'd13, 4'd12, 4'd6), 1'b0, 4'd0, 64'd0, " bad op");
    peek(4'd13, 4'd0, 4'd14, " R8 dest unchanged");

    // R11 back-to-back dependency
    step(1'b1, mk(2'd3, 3'd4, 4'd2, 4'd12, 4'd12), 1'b0, 4'd0, 64'd0, " R11 first");
    step(1'b1, mk(2'd3, 3'd4, 4'd15, 4'd2, 4'd2), 1'b0, 4'd0, 64'd0, " R11 dependent");

    // R10: fill and instruction hit the same register in one cycle
    step(1'b1, mk(2'd3, 3'd5, 4'd5, 4'd5, 4'd12), 1'b1, 4'd5, 64'hDEAD_BEEF_0000_0001,
         " R10 collision");
    step(1'b1, mk(2'd3, 3'd5, 4'd9, 4'd6, 4'd0), 1'b1, 4'd6, 64'd42, " R10 read before fill");
    peek(4'd6, 4'd0, 4'd9, " R10 fill landed");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      logic [3:0]  d, s1, s2;
      logic [1:0]  g;
      logic [2:0]  o;
      logic [63:0] fv;
      int          pick;
      bit          iss, fw;
      d  = 4'($urandom % 16);
      s1 = 4'($urandom % 16);
      s2 = 4'($urandom % 16);
      g  = 2'($urandom % 4);
      o  = 3'($urandom % 8);
      pick = $urandom % 6;
      case (pick)
        0:       fv = 64'h8000_0000_0000_0000;
        1:       fv = {32'hFFFF_FFFF, 32'h8000_0000};
        2:       fv = 64'($urandom % 5);
        default: fv = {$urandom, $urandom};
      endcase
      iss = ($urandom % 8) != 0;
      fw  = ($urandom % 3) == 0;
      step(iss, mk(g, o, d, s1, s2), fw, 4'($urandom % 16), fv, " random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule